// File: doc/BRIEF.md
# Embedded Controller Host Mailbox

This block is the device side of a byte-wide host interface to an embedded controller. The host sees two ports: a data port, and a second port that returns status when read and takes a command when written. Each write first sets the input-buffer-full flag. After a fixed number of cycles the block consumes the byte and clears the flag. A command byte followed by one or two data bytes gives the host read or write access to a 256-byte register space behind the block.

The host polls input-buffer-full clear before each write and output-buffer-full set before reading the data port. A read command returns the addressed byte in the data port. A write command stores a byte through the register-space port. Two further commands set and clear a burst flag, which is recorded and has no other effect. The back-end port presents an address, a write strobe and write data. It returns read data one cycle after the address.

Top module: `ec_mailbox`

## Requirements
- R1: After reset the status byte is 0x00, the data port reads 0x00 and reg_we is low.
- R2: host_port=0 selects the data port and host_port=1 the status/command port. An accepted write sets status bit 1 (input full). It sets status bit 3 when the byte went to the command port and clears bit 3 when it went to the data port.
- R3: Status bit 1 stays set for exactly IBF_DELAY cycles after the accepting edge. A host write that arrives while bit 1 is set is dropped.
- R4: Command 0x80 followed by an address byte loads the addressed register into the data port. Status bit 0 (output full) is set two cycles after bit 1 clears for the address byte.
- R5: A host read of the data port clears status bit 0.
- R6: Command 0x81, an address byte and a data byte produce exactly one reg_we pulse with that address and data. The pulse comes in the cycle after bit 1 clears for the data byte.
- R7: Command 0x82 sets status bit 4 (burst) and command 0x83 clears it.
- R8: Status bits 2, 5, 6 and 7 always read zero.
- R9: A command byte consumed in the middle of a sequence abandons that sequence and starts decoding from the new command.
- R10: An unknown command byte is consumed with no effect. Later data bytes cause no register write and no data-port load.
- R11: If a host data-port read falls in the same cycle as a data-port load, the load wins. Bit 0 stays set and the new byte is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_port | input | 1 | 0 = data port, 1 = status/command port |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte or data-port byte, selected by host_port |
| reg_addr | output | 8 | Register-space address |
| reg_we | output | 1 | Register-space write strobe |
| reg_wdata | output | 8 | Register-space write byte |
| reg_rdata | input | 8 | Register-space read byte, valid one cycle after reg_addr |

## Verification
Two events can fall on the same edge: the host reading the data port, which clears output-full, and the block loading a fetched register value, which sets it. The bench leaves a previous result unread and issues a second read command. It then raises the host read strobe in exactly the cycle whose closing edge captures the new value. The check is that output-full is still set afterwards and the data port holds the second register, not the first.

// File: rtl/ec_mailbox.sv
module ec_mailbox #(
  parameter int IBF_DELAY = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_port,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic [7:0] reg_addr,
  output logic       reg_we,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);
  localparam int CW = $clog2(IBF_DELAY + 1);
  localparam logic [7:0] OP_RD = 8'h80, OP_WR = 8'h81, OP_BON = 8'h82, OP_BOFF = 8'h83;

  typedef enum logic [2:0] {S_IDLE, S_RADDR, S_WADDR, S_WDATA, S_FETCH, S_CAPT} seq_t;

  seq_t          st;
  logic          ibf, obf, cmd_flag, burst, we_q;
  logic [7:0]    inbuf, obuf, addr_q, wdata_q;
  logic [CW-1:0] cnt;

  wire accept  = host_wr && !ibf;
  wire consume = ibf && (cnt == CW'(1));
  wire cap     = (st == S_CAPT);
  wire rd_data = host_rd && !host_port;
  wire [7:0] status = {3'b000, burst, cmd_flag, 1'b0, ibf, obf};

  assign host_rdata = host_port ? status : obuf;
  assign reg_addr   = addr_q;
  assign reg_we     = we_q;
  assign reg_wdata  = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ibf <= 1'b0; obf <= 1'b0; cmd_flag <= 1'b0; burst <= 1'b0; we_q <= 1'b0;
      inbuf <= '0; obuf <= '0; addr_q <= '0; wdata_q <= '0; cnt <= '0;
    end else begin
      we_q <= 1'b0;

      if (accept) begin
        ibf      <= 1'b1;
        cnt      <= CW'(IBF_DELAY);
        inbuf    <= host_wdata;
        cmd_flag <= host_port;
      end else if (consume) begin
        ibf <= 1'b0;
      end else if (ibf) begin
        cnt <= cnt - CW'(1);
      end

      if (cap) begin
        obuf <= reg_rdata;
        obf  <= 1'b1;
      end else if (rd_data) begin
        obf <= 1'b0;
      end

      if (consume && cmd_flag) begin
        case (inbuf)
          OP_RD:   st <= S_RADDR;
          OP_WR:   st <= S_WADDR;
          OP_BON:  begin burst <= 1'b1; st <= S_IDLE; end
          OP_BOFF: begin burst <= 1'b0; st <= S_IDLE; end
          default: st <= S_IDLE;
        endcase
      end else begin
        case (st)
          S_RADDR: if (consume) begin addr_q <= inbuf; st <= S_FETCH; end
          S_WADDR: if (consume) begin addr_q <= inbuf; st <= S_WDATA; end
          S_WDATA: if (consume) begin wdata_q <= inbuf; we_q <= 1'b1; st <= S_IDLE; end
          S_FETCH: st <= S_CAPT;
          S_CAPT:  st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module ec_mailbox_chk (
  input logic clk,
  input logic rst_n,
  input logic host_wr,
  input logic host_rd,
  input logic host_port,
  input logic ibf,
  input logic obf,
  input logic cap,
  input logic reg_we
);
  // R3
  ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !ibf) |=> ibf);
  // R3
  ibf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf) |-> $past(host_wr));
  // R6
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  // R5
  obf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (obf && host_rd && !host_port && !cap) |=> !obf);
  // R4
  obf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obf) |-> $past(cap));
  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && host_rd && !host_port) |=> obf);
endmodule

bind ec_mailbox ec_mailbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_port(host_port), .ibf(ibf), .obf(obf), .cap(cap), .reg_we(reg_we)
);

// File: tb/tb_ec_mailbox.sv
module tb_ec_mailbox;
  localparam int D = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_port = 1'b1, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata, reg_addr, reg_wdata, reg_rdata;
  logic reg_we;

  ec_mailbox #(.IBF_DELAY(D)) dut (
    .clk(clk), .rst_n(rst_n), .host_port(host_port), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] seed_val(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  logic [7:0] mem [256];
  logic [7:0] model [256];
  logic [7:0] mem_q;
  int we_cnt = 0;
  int n_chk = 0, n_fail = 0;

  assign reg_rdata = mem_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= seed_val(i);
      mem_q <= '0;
    end else begin
      if (reg_we) begin
        mem[reg_addr] <= reg_wdata;
        we_cnt <= we_cnt + 1;
      end
      mem_q <= mem[reg_addr];
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic raw_write(logic port, logic [7:0] v);
    @(negedge clk);
    host_port = port; host_wdata = v; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_port = 1'b1;
    #1;
  endtask

  task automatic wait_ibf();
    while (host_rdata[1]) @(negedge clk);
  endtask

  task automatic put(logic port, logic [7:0] v);
    wait_ibf();
    raw_write(port, v);
  endtask

  task automatic get_data(output logic [7:0] v);
    while (!host_rdata[0]) @(negedge clk);
    host_port = 1'b0; #1;
    v = host_rdata;
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; host_port = 1'b1;
    #1;
  endtask

  task automatic ec_read(logic [7:0] a, output logic [7:0] v);
    put(1'b1, 8'h80);
    put(1'b0, a);
    get_data(v);
  endtask

  task automatic ec_write(logic [7:0] a, logic [7:0] d);
    put(1'b1, 8'h81);
    put(1'b0, a);
    put(1'b0, d);
    wait_ibf();
    repeat (2) @(negedge clk);
    #1;
    model[a] = d;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v, a, d;
    int cnt, w0;
    void'($urandom(1234));
    for (int i = 0; i < 256; i++) model[i] = seed_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    chk("R1 status", host_rdata, 8'h00);
    chk("R1 reg_we", reg_we, 0);
    host_port = 1'b0; #1;
    chk("R1 data port", host_rdata, 8'h00);
    host_port = 1'b1; #1;

    // R2 data-port write marks bit3 clear, R3 exact delay
    raw_write(1'b0, 8'h55);
    chk("R2 data write flags", host_rdata & 8'h0A, 8'h02);
    cnt = 0;
    while (host_rdata[1]) begin cnt++; @(negedge clk); #1; end
    chk("R3 ibf duration", 16'(cnt), 16'(D));
    chk("R2 stray data no write", 16'(we_cnt), 0);

    // R2 command-port write marks bit3 set
    raw_write(1'b1, 8'h83);
    chk("R2 cmd write flags", host_rdata & 8'h0A, 8'h0A);

    // R7 burst on
    put(1'b1, 8'h82); wait_ibf(); #1;
    chk("R7 burst set", host_rdata[4], 1);
    // R3 write while full is dropped
    raw_write(1'b1, 8'h82);
    raw_write(1'b1, 8'h83);
    wait_ibf(); #1;
    chk("R3 dropped write", host_rdata[4], 1);
    put(1'b1, 8'h83); wait_ibf(); #1;
    chk("R7 burst clear", host_rdata[4], 0);
    // R8 reserved bits
    chk("R8 reserved bits", host_rdata & 8'hE4, 0);

    // R4 read latency and value
    put(1'b1, 8'h80);
    put(1'b0, 8'h07);
    wait_ibf(); #1;
    chk("R4 obf at ibf clear", host_rdata[0], 0);
    @(negedge clk); #1;
    chk("R4 obf one later", host_rdata[0], 0);
    @(negedge clk); #1;
    chk("R4 obf set", host_rdata[0], 1);
    chk("R8 reserved with obf", host_rdata & 8'hE4, 0);
    get_data(v);
    chk("R4 read value", v, model[7]);
    chk("R5 obf cleared", host_rdata[0], 0);
    ec_read(8'hFF, v);
    chk("R4 read top address", v, model[255]);

    // R6 write
    w0 = we_cnt;
    ec_write(8'h10, 8'hA5);
    chk("R6 single pulse", 16'(we_cnt - w0), 1);
    ec_read(8'h10, v);
    chk("R6 written value", v, 8'hA5);

    // R9 abort write with a new read
    w0 = we_cnt;
    put(1'b1, 8'h81);
    put(1'b0, 8'h20);
    put(1'b1, 8'h80);
    put(1'b0, 8'h21);
    get_data(v);
    chk("R9 restarted read", v, model[8'h21]);
    chk("R9 no write", 16'(we_cnt - w0), 0);
    ec_read(8'h20, v);
    chk("R9 target untouched", v, model[8'h20]);

    // R10 unknown command
    w0 = we_cnt;
    put(1'b1, 8'h7E);
    put(1'b0, 8'h30);
    put(1'b0, 8'h31);
    wait_ibf();
    repeat (4) @(negedge clk);
    #1;
    chk("R10 no write", 16'(we_cnt - w0), 0);
    chk("R10 no load", host_rdata[0], 0);

    // R11 read clear and load on the same edge
    put(1'b1, 8'h80);
    put(1'b0, 8'h40);
    while (!host_rdata[0]) @(negedge clk);
    put(1'b1, 8'h80);
    put(1'b0, 8'h41);
    wait_ibf();
    @(negedge clk);
    host_port = 1'b0; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; host_port = 1'b1; #1;
    chk("R11 obf kept", host_rdata[0], 1);
    get_data(v);
    chk("R11 new byte", v, model[8'h41]);

    // random mix, R4 and R6
    for (int k = 0; k < 60; k++) begin
      a = 8'($urandom);
      d = 8'($urandom);
      if ($urandom % 2 == 0) begin
        w0 = we_cnt;
        ec_write(a, d);
        chk("R6 random write pulse", 16'(we_cnt - w0), 1);
      end else begin
        ec_read(a, v);
        chk("R4 random read", v, model[a]);
      end
      chk("R8 random status", host_rdata & 8'hE4, 0);
    end

    summary();
    $finish;
  end
endmodule